// File: doc/BRIEF.md
# Flash command state machine

This block models the command front end of a byte-wide NOR flash device placed in front of a small internal storage array. Every bus write is taken as a command byte, or as the second byte of a two-write sequence. The block keeps a read mode, and a read returns one of three things according to that mode: array contents, identification and lock information, or a status byte. The storage is split into equal blocks. Each block has its own lock bit, and one master lock bit guards the block lock bits.

Program, erase and lock changes take effect as soon as the write that completes them is accepted. A cycle counter then holds the device busy for a set number of cycles. While busy, every read returns status and every write is dropped. A failed operation sets error flags in the status byte. These flags stay set until software issues the clear command. One output reports whether any error flag is set.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the whole array reads 0xFF, all lock bits are clear, `ready` is 1, the read mode is array, and a status read returns 0x80.
- R2: Write 0xFF selects array reads, 0x90 selects identification reads, and 0x70 selects status reads. Write 0x50 clears the error bits and leaves the read mode unchanged. The first writes 0x20, 0x40 and 0x60 switch reads to status.
- R3: In identification mode the in-block offset selects the byte read. Offset 0 reads 0x89, offset 1 reads 0xA6, and offset 3 reads the master lock in bit 0. Offset 2 reads, in bit 0, the lock bit of the block named by the upper address bits. Any other offset reads 0x00.
- R4: The status byte has ready in bit 7 (1 = idle), the erase/lock-clear error in bit 5, the program/lock-set error in bit 4, and device protect in bit 1. All other bits read 0.
- R5: Write 0x20 followed by 0xD0 erases the addressed block to 0xFF. No other block changes.
- R6: Write 0x40 followed by a data byte stores old AND data at the addressed byte, so programming can only clear bits.
- R7: An accepted erase, program or lock change drives `ready` low for exactly BUSY_CYCLES cycles. In that window, reads return status in every mode, and writes are ignored.
- R8: After 0x60, a second write of 0x01 locks the addressed block, 0xF1 sets the master lock, and 0xD0 unlocks every block. While the master lock is set, 0x01 instead sets bits 4 and 1, and 0xD0 sets bits 5 and 1.
- R9: Erasing a locked block sets status bits 5 and 1. Programming a locked block sets bits 4 and 1. In both cases the array stays unchanged and no busy period starts.
- R10: A second write that does not fit the pending sequence sets bits 4 and 5, selects status reads, and changes neither the array nor the locks.
- R11: The error bits persist through every command except 0x50. `err_any` is the OR of status bits 1, 3, 4 and 5.
- R12: A first write with an unlisted code has no effect: the mode, array, locks and status all stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | $clog2(BLK_COUNT)+OFF_W | Byte address: block index above the in-block offset |
| wdata | input | 8 | Write byte (command or data) |
| rdata | output | 8 | Read byte for `addr` in the current mode (combinational) |
| ready | output | 1 | 1 when no busy period is running |
| err_any | output | 1 | Any error status bit set |

## Verification
The assertions assume that `addr` and `wdata` are stable during any cycle in which `wr_en` is high, and that BUSY_CYCLES is at least one. The sequence and busy checks also assume that no write arrives in the same cycle as reset release. The bench drives every input one time step after a rising edge, so all inputs stay stable for the whole following cycle. A random phase then issues command codes, second-write bytes and random addresses, including writes that land inside busy windows and unrecognised second writes. A behavioural model follows every one of these writes.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_ERASE = 2'd1,
        PEND_PROG  = 2'd2,
        PEND_LOCK  = 2'd3
    } pend_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } op_e;

    // first-write command codes
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_CLEAR      = 8'h50;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_PROG       = 8'h40;
    localparam logic [7:0] CMD_LOCK       = 8'h60;

    // second-write codes
    localparam logic [7:0] SUB_CONFIRM    = 8'hD0;
    localparam logic [7:0] SUB_BLK_LOCK   = 8'h01;
    localparam logic [7:0] SUB_MASTER     = 8'hF1;
    localparam logic [7:0] SUB_UNLOCK_ALL = 8'hD0;

    // identification bytes
    localparam logic [7:0] ID_MAKER  = 8'h89;
    localparam logic [7:0] ID_DEVICE = 8'hA6;

endpackage

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int BLK_COUNT   = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [$clog2(BLK_COUNT)-1:0] blk_i,
    input  logic [7:0]                   wdata_i,
    output op_e                          op_o,
    output mode_e                        mode_o,
    output logic                         ready_o,
    output logic [7:0]                   status_o,
    output logic [BLK_COUNT-1:0]         locks_o,
    output logic                         master_o,
    output logic                         err_any_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

    typedef struct packed {
        mode_e                mode;
        pend_e                pend;
        logic [CNT_W-1:0]     cnt;
        logic                 err_erase;
        logic                 err_prog;
        logic                 err_prot;
        logic                 master;
        logic [BLK_COUNT-1:0] locks;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        op_o = OP_NONE;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (wr_en_i) begin
            case (st_q.pend)
                PEND_ERASE: begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = MODE_STATUS;
                    if (wdata_i != SUB_CONFIRM) begin
                        st_d.err_erase = 1'b1;
                        st_d.err_prog  = 1'b1;
                    end else if (st_q.locks[blk_i]) begin
                        st_d.err_erase = 1'b1;
                        st_d.err_prot  = 1'b1;
                    end else begin
                        op_o     = OP_ERASE;
                        st_d.cnt = BUSY_LOAD;
                    end
                end
                PEND_PROG: begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = MODE_STATUS;
                    if (st_q.locks[blk_i]) begin
                        st_d.err_prog = 1'b1;
                        st_d.err_prot = 1'b1;
                    end else begin
                        op_o     = OP_PROG;
                        st_d.cnt = BUSY_LOAD;
                    end
                end
                PEND_LOCK: begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = MODE_STATUS;
                    case (wdata_i)
                        SUB_BLK_LOCK: begin
                            if (st_q.master) begin
                                st_d.err_prog = 1'b1;
                                st_d.err_prot = 1'b1;
                            end else begin
                                st_d.locks[blk_i] = 1'b1;
                                st_d.cnt          = BUSY_LOAD;
                            end
                        end
                        SUB_MASTER: begin
                            st_d.master = 1'b1;
                            st_d.cnt    = BUSY_LOAD;
                        end
                        SUB_UNLOCK_ALL: begin
                            if (st_q.master) begin
                                st_d.err_erase = 1'b1;
                                st_d.err_prot  = 1'b1;
                            end else begin
                                st_d.locks = '0;
                                st_d.cnt   = BUSY_LOAD;
                            end
                        end
                        default: begin
                            st_d.err_erase = 1'b1;
                            st_d.err_prog  = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (wdata_i)
                        CMD_READ_ARRAY: st_d.mode = MODE_ARRAY;
                        CMD_IDENT:      st_d.mode = MODE_IDENT;
                        CMD_STATUS:     st_d.mode = MODE_STATUS;
                        CMD_CLEAR: begin
                            st_d.err_erase = 1'b0;
                            st_d.err_prog  = 1'b0;
                            st_d.err_prot  = 1'b0;
                        end
                        CMD_ERASE: begin
                            st_d.pend = PEND_ERASE;
                            st_d.mode = MODE_STATUS;
                        end
                        CMD_PROG: begin
                            st_d.pend = PEND_PROG;
                            st_d.mode = MODE_STATUS;
                        end
                        CMD_LOCK: begin
                            st_d.pend = PEND_LOCK;
                            st_d.mode = MODE_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_ARRAY, pend: PEND_NONE, cnt: '0,
                      err_erase: 1'b0, err_prog: 1'b0, err_prot: 1'b0,
                      master: 1'b0, locks: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o   = (st_q.cnt == '0);
    assign status_o  = {ready_o, 1'b0, st_q.err_erase, st_q.err_prog,
                        1'b0, 1'b0, st_q.err_prot, 1'b0};
    assign err_any_o = status_o[1] | status_o[3] | status_o[4] | status_o[5];
    assign mode_o    = st_q.mode;
    assign locks_o   = st_q.locks;
    assign master_o  = st_q.master;

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && wr_en_i) |=> ($stable(st_q.mode) && $stable(st_q.locks) && $stable(st_q.master))); // R7

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= BUSY_LOAD); // R7

    AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err_prog && !(ready_o && wr_en_i && st_q.pend == PEND_NONE && wdata_i == CMD_CLEAR))
        |=> st_q.err_prog); // R11

    AST_PROTECT_WITH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err_prot) |-> (st_q.err_prog || st_q.err_erase)); // R9

    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && wr_en_i && st_q.pend == PEND_ERASE && wdata_i != SUB_CONFIRM)
        |=> (st_q.err_erase && st_q.err_prog && st_q.mode == MODE_STATUS && ready_o)); // R10

endmodule

// File: rtl/flash_cmd_array.sv
`timescale 1ns/1ps
module flash_cmd_array
    import flash_cmd_pkg::*;
#(
    parameter int BLK_COUNT = 16,
    parameter int OFF_W     = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  op_e                                op_i,
    input  logic [$clog2(BLK_COUNT)+OFF_W-1:0] op_addr_i,
    input  logic [7:0]                         op_data_i,
    input  logic [$clog2(BLK_COUNT)+OFF_W-1:0] rd_addr_i,
    output logic [7:0]                         rd_data_o
);

    localparam int BLK_W     = $clog2(BLK_COUNT);
    localparam int ADDR_W    = BLK_W + OFF_W;
    localparam int BLK_BYTES = 1 << OFF_W;
    localparam int DEPTH     = BLK_COUNT * BLK_BYTES;

    logic [7:0]       mem_d [DEPTH];
    logic [7:0]       mem_q [DEPTH];
    logic [BLK_W-1:0] op_blk;

    assign op_blk = op_addr_i[ADDR_W-1:OFF_W];

    always_comb begin
        mem_d = mem_q;
        case (op_i)
            OP_ERASE: begin
                for (int i = 0; i < BLK_BYTES; i++) begin
                    mem_d[{op_blk, OFF_W'(i)}] = 8'hFF;
                end
            end
            OP_PROG: mem_d[op_addr_i] = mem_q[op_addr_i] & op_data_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // observation registers used only by the properties below
    logic [ADDR_W-1:0] chk_addr_q;
    logic [7:0]        chk_old_q;
    always_ff @(posedge clk) begin
        chk_addr_q <= op_addr_i;
        chk_old_q  <= mem_q[op_addr_i];
    end

    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ERASE) |=> (mem_q[chk_addr_q] == 8'hFF)); // R5

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PROG) |=> ((mem_q[chk_addr_q] & ~chk_old_q) == 8'h00)); // R6

    AST_NO_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NONE) |=> (mem_q[chk_addr_q] == chk_old_q)); // R9

endmodule

// File: rtl/flash_cmd_rdmux.sv
`timescale 1ns/1ps
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int BLK_COUNT = 16,
    parameter int OFF_W     = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  mode_e                              mode_i,
    input  logic                               ready_i,
    input  logic [7:0]                         status_i,
    input  logic [BLK_COUNT-1:0]               locks_i,
    input  logic                               master_i,
    input  logic [$clog2(BLK_COUNT)+OFF_W-1:0] addr_i,
    input  logic [7:0]                         arr_byte_i,
    output logic [7:0]                         rdata_o
);

    localparam int BLK_W  = $clog2(BLK_COUNT);
    localparam int ADDR_W = BLK_W + OFF_W;

    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;

    assign blk = addr_i[ADDR_W-1:OFF_W];
    assign off = addr_i[OFF_W-1:0];

    always_comb begin
        rdata_o = status_i;
        if (ready_i) begin
            case (mode_i)
                MODE_ARRAY: rdata_o = arr_byte_i;
                MODE_IDENT: begin
                    case (off)
                        OFF_W'(0): rdata_o = ID_MAKER;
                        OFF_W'(1): rdata_o = ID_DEVICE;
                        OFF_W'(2): rdata_o = {7'b0, locks_i[blk]};
                        OFF_W'(3): rdata_o = {7'b0, master_i};
                        default:   rdata_o = 8'h00;
                    endcase
                end
                default: rdata_o = status_i;
            endcase
        end
    end

    AST_IDLE_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && mode_i == MODE_STATUS) |-> rdata_o[7]); // R4

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int BLK_COUNT   = 16,
    parameter int OFF_W       = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(BLK_COUNT)+OFF_W-1:0] addr,
    input  logic [7:0]                         wdata,
    output logic [7:0]                         rdata,
    output logic                               ready,
    output logic                               err_any
);

    localparam int BLK_W  = $clog2(BLK_COUNT);
    localparam int ADDR_W = BLK_W + OFF_W;

    op_e                  op;
    mode_e                mode;
    logic [7:0]           status;
    logic [BLK_COUNT-1:0] locks;
    logic                 master;
    logic [7:0]           arr_byte;

    flash_cmd_fsm #(
        .BLK_COUNT  (BLK_COUNT),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .blk_i    (addr[ADDR_W-1:OFF_W]),
        .wdata_i  (wdata),
        .op_o     (op),
        .mode_o   (mode),
        .ready_o  (ready),
        .status_o (status),
        .locks_o  (locks),
        .master_o (master),
        .err_any_o(err_any)
    );

    flash_cmd_array #(
        .BLK_COUNT(BLK_COUNT),
        .OFF_W    (OFF_W)
    ) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .op_addr_i(addr),
        .op_data_i(wdata),
        .rd_addr_i(addr),
        .rd_data_o(arr_byte)
    );

    flash_cmd_rdmux #(
        .BLK_COUNT(BLK_COUNT),
        .OFF_W    (OFF_W)
    ) i_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .ready_i   (ready),
        .status_i  (status),
        .locks_i   (locks),
        .master_i  (master),
        .addr_i    (addr),
        .arr_byte_i(arr_byte),
        .rdata_o   (rdata)
    );

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

    localparam int NBLK  = 16;
    localparam int OFFW  = 4;
    localparam int BUSY  = 4;
    localparam int AW    = 8;
    localparam int NBYTE = 256;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          ready;
    logic          err_any;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_cmd_ctrl #(.BLK_COUNT(NBLK), .OFF_W(OFFW), .BUSY_CYCLES(BUSY)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .err_any(err_any)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [NBYTE];
    bit         m_lock [NBLK];
    bit         m_master;
    int         m_mode;     // 0 array, 1 ident, 2 status
    int         m_pend;     // 0 none, 1 erase, 2 program, 3 lock
    int         m_cnt;
    bit         m_e5, m_e4, m_e1;
    int         mb;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTE; i++) m_mem[i] = 8'hFF;
            for (int i = 0; i < NBLK; i++) m_lock[i] = 1'b0;
            m_master = 0; m_mode = 0; m_pend = 0; m_cnt = 0;
            m_e5 = 0; m_e4 = 0; m_e1 = 0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end else if (wr_en) begin
            mb = int'(addr) / (1 << OFFW);
            if (m_pend != 0) begin
                m_mode = 2;
                if (m_pend == 1) begin
                    if (wdata != 8'hD0) begin m_e5 = 1; m_e4 = 1; end
                    else if (m_lock[mb]) begin m_e5 = 1; m_e1 = 1; end
                    else begin
                        for (int j = 0; j < (1 << OFFW); j++) m_mem[mb * (1 << OFFW) + j] = 8'hFF;
                        m_cnt = BUSY;
                    end
                end else if (m_pend == 2) begin
                    if (m_lock[mb]) begin m_e4 = 1; m_e1 = 1; end
                    else begin m_mem[addr] = m_mem[addr] & wdata; m_cnt = BUSY; end
                end else begin
                    if (wdata == 8'h01) begin
                        if (m_master) begin m_e4 = 1; m_e1 = 1; end
                        else begin m_lock[mb] = 1; m_cnt = BUSY; end
                    end else if (wdata == 8'hF1) begin
                        m_master = 1; m_cnt = BUSY;
                    end else if (wdata == 8'hD0) begin
                        if (m_master) begin m_e5 = 1; m_e1 = 1; end
                        else begin
                            for (int j = 0; j < NBLK; j++) m_lock[j] = 0;
                            m_cnt = BUSY;
                        end
                    end else begin
                        m_e5 = 1; m_e4 = 1;
                    end
                end
                m_pend = 0;
            end else begin
                case (wdata)
                    8'hFF: m_mode = 0;
                    8'h90: m_mode = 1;
                    8'h70: m_mode = 2;
                    8'h50: begin m_e5 = 0; m_e4 = 0; m_e1 = 0; end
                    8'h20: begin m_pend = 1; m_mode = 2; end
                    8'h40: begin m_pend = 2; m_mode = 2; end
                    8'h60: begin m_pend = 3; m_mode = 2; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] model_status();
        return {(m_cnt == 0), 1'b0, m_e5, m_e4, 1'b0, 1'b0, m_e1, 1'b0};
    endfunction

    function automatic logic [7:0] model_read(input logic [AW-1:0] a);
        int off;
        off = int'(a) % (1 << OFFW);
        if (m_cnt > 0 || m_mode == 2) return model_status();
        if (m_mode == 0) return m_mem[a];
        case (off)
            0: return 8'h89;
            1: return 8'hA6;
            2: return {7'b0, m_lock[int'(a) / (1 << OFFW)]};
            3: return {7'b0, m_master};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R7 ready", int'(ready), int'(m_cnt == 0));
            chk("R11 err_any", int'(err_any), int'(m_e1 | m_e4 | m_e5));
            if (m_cnt > 0 || m_mode == 2) chk("R4 status read", int'(rdata), int'(model_read(addr)));
            else if (m_mode == 1)         chk("R3 ident read", int'(rdata), int'(model_read(addr)));
            else                          chk("R6 array read", int'(rdata), int'(model_read(addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        @(negedge clk);
        chk(tag, int'(rdata), int'(exp));
        @(posedge clk); #1;
    endtask

    task automatic settle();
        repeat (BUSY) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        cmp_on = 1'b0;
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        cmp_on = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [7:0] cmd_pool [12] = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'h40,
                                  8'h60, 8'hD0, 8'h01, 8'hF1, 8'h33, 8'h00};

    initial begin
        do_reset();
        // R1: reset state
        look(8'h00, 8'hFF, "R1 array after reset");
        look(8'hFF, 8'hFF, "R1 array last byte");
        chk("R1 ready after reset", int'(ready), 1);
        wr(8'h00, 8'h70);
        look(8'h00, 8'h80, "R1 status after reset");

        // R3: identification reads
        wr(8'h00, 8'h90);
        look(8'h00, 8'h89, "R3 maker");
        look(8'h01, 8'hA6, "R3 device");
        look(8'h03, 8'h00, "R3 master clear");
        look(8'h52, 8'h00, "R3 block5 unlocked");
        look(8'h04, 8'h00, "R3 other offset");

        // R6, R7: program and busy window
        wr(8'h00, 8'hFF);
        wr(8'h13, 8'h40);
        look(8'h13, 8'h80, "R2 first write selects status");
        wr(8'h13, 8'h5A);
        addr = 8'h13;
        @(negedge clk);
        chk("R7 ready low after program", int'(ready), 0);
        chk("R7 busy read is status", int'(rdata), 8'h00);
        settle();
        look(8'h13, 8'h80, "R2 status after program");
        wr(8'h00, 8'hFF);
        look(8'h13, 8'h5A, "R6 programmed byte");
        wr(8'h13, 8'h40); wr(8'h13, 8'h0F); settle();
        wr(8'h00, 8'hFF);
        look(8'h13, 8'h0A, "R6 program ANDs");

        // R7: write during busy is dropped
        wr(8'h20, 8'h40); wr(8'h20, 8'h00);
        wr(8'h00, 8'h90);
        settle();
        look(8'h00, 8'h80, "R7 write while busy ignored");

        // R5: erase block 1 only
        wr(8'h15, 8'h20); wr(8'h15, 8'hD0); settle();
        wr(8'h00, 8'hFF);
        look(8'h13, 8'hFF, "R5 erased byte");
        look(8'h20, 8'h00, "R5 other block kept");

        // R8, R9: block lock and protected program/erase
        wr(8'h25, 8'h60); wr(8'h25, 8'h01); settle();
        wr(8'h00, 8'h90);
        look(8'h22, 8'h01, "R8 block2 locked");
        look(8'h32, 8'h00, "R8 block3 unlocked");
        wr(8'h20, 8'h40); wr(8'h20, 8'hFF);
        chk("R9 no busy on protect", int'(ready), 1);
        look(8'h20, 8'h92, "R9 program locked status");
        wr(8'h00, 8'hFF);
        chk("R11 error sticky over FF", int'(err_any), 1);
        look(8'h20, 8'h00, "R9 locked byte unchanged");
        wr(8'h00, 8'h50); wr(8'h00, 8'h70);
        look(8'h00, 8'h80, "R11 clear status");
        wr(8'h21, 8'h20); wr(8'h21, 8'hD0);
        look(8'h21, 8'hA2, "R9 erase locked status");
        wr(8'h00, 8'h50);

        // R10: bad second writes
        wr(8'h44, 8'h20); wr(8'h44, 8'h33);
        look(8'h44, 8'hB0, "R10 bad erase confirm");
        wr(8'h00, 8'h50);
        wr(8'h44, 8'h60); wr(8'h44, 8'h77);
        look(8'h44, 8'hB0, "R10 bad lock sub");
        wr(8'h00, 8'h50);
        wr(8'h00, 8'hFF);
        look(8'h44, 8'hFF, "R10 array untouched");

        // R8: master lock blocks lock changes
        wr(8'h00, 8'h60); wr(8'h00, 8'hF1); settle();
        wr(8'h00, 8'h90);
        look(8'h03, 8'h01, "R8 master set");
        wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
        look(8'h00, 8'hA2, "R8 unlock refused");
        wr(8'h00, 8'h50);
        wr(8'h30, 8'h60); wr(8'h30, 8'h01);
        look(8'h00, 8'h92, "R8 block lock refused");
        wr(8'h00, 8'h50);

        // R12 and R2: unknown first write, clear keeps mode
        wr(8'h00, 8'hFF);
        wr(8'h00, 8'h12);
        look(8'h13, 8'hFF, "R12 unknown code ignored");
        wr(8'h00, 8'h90);
        wr(8'h00, 8'h50);
        look(8'h00, 8'h89, "R2 clear keeps ident mode");

        // R8: unlock-all without master
        do_reset();
        wr(8'h45, 8'h60); wr(8'h45, 8'h01); settle();
        wr(8'h00, 8'h90);
        look(8'h42, 8'h01, "R8 block4 locked");
        wr(8'h00, 8'h60); wr(8'h00, 8'hD0); settle();
        wr(8'h00, 8'h90);
        look(8'h42, 8'h00, "R8 unlock all");

        // random phase, compared every cycle against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                addr = AW'($urandom_range(0, NBYTE - 1));
                @(posedge clk); #1;
            end else begin
                wr(AW'($urandom_range(0, NBYTE - 1)),
                   ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                               : cmd_pool[$urandom_range(0, 11)]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule